// File: doc/BRIEF.md
# Mode-Register Write Guard

This block sits in a DDR3-class memory controller between the command scheduler and the DRAM command bus. It takes mode-register write requests over a request/acknowledge pair. It issues the write only when every bank is closed and quiet. After the write it enforces a blackout on the command bus.

During the blackout every scheduler command is stalled through a ready signal and is never lost. On-die termination is forced off, and clock-enable is held high until a separate power-down-entry delay has run out. A phase output shows whether the register holds its old setting, is being updated, or holds the new setting. A one-cycle pulse marks the first cycle in which the new setting is in effect.

Both delays are cycle counts that the block captures once after reset.

Top module: `mrs_guard`

## Requirements
- R1: The update delay tMOD and the power-down-entry delay tPD are captured from `cfg_tmod_i` and `cfg_tpd_i` on the first clock edge after reset is released. A captured value of 0 is used as 1. No request is acknowledged in the cycle before that capture.
- R2: `mrs_ack_o` is high only while `mrs_req_i` is high and all of these hold: every bit of `bank_pre_i` is 1, every bit of `bank_trp_ok_i` is 1, and `burst_busy_i` is 0. Otherwise the request waits unacknowledged.
- R3: In the acknowledge cycle (T0), `cmd_o` carries the mode-register code 3'd2, with `sel_o` = `mrs_sel_i` and `addr_o` = `mrs_data_i`.
- R4: In cycles T0 to T0+tMOD-1, `sched_ready_o` is 0. In cycles T0+1 to T0+tMOD-1, `cmd_o` is NOP (3'd0).
- R5: A scheduler command that is stalled stays pending and appears on `cmd_o` unchanged in cycle T0+tMOD. Outside the window, a command passes in the same cycle with `sched_ready_o` high.
- R6: `odt_o` is 0 in cycles T0 to T0+tMOD-1. In every other cycle it follows `odt_i`.
- R7: `cke_o` is 1 in cycles T0 to T0+tPD-1. In every other cycle it follows `cke_i`.
- R8: `phase_o` reads 0 (old setting) before the first write. It reads 1 (updating) in cycles T0 to T0+tMOD-1, and 2 (new setting) after that.
- R9: `applied_o` is high for exactly one cycle, T0+tMOD.
- R10: A second write request made during the window is acknowledged only at T0+tMOD. An allowed write takes the bus ahead of a scheduler command presented in the same cycle, and that command is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_tmod_i | input | CW | Update delay in cycles, captured after reset |
| cfg_tpd_i | input | CW | Power-down-entry delay in cycles, captured after reset |
| mrs_req_i | input | 1 | Mode-register write request, held until acknowledged |
| mrs_sel_i | input | SW | Mode-register select |
| mrs_data_i | input | DW | Mode-register value |
| mrs_ack_o | output | 1 | Write accepted and issued this cycle |
| bank_pre_i | input | NB | Per-bank precharged flag |
| bank_trp_ok_i | input | NB | Per-bank precharge period elapsed |
| burst_busy_i | input | 1 | Data burst in progress |
| sched_cmd_i | input | 3 | Scheduler command (0 NOP, 1 DES, 2 MRS, 3 ACT, 4 RD, 5 WR, 6 PRE, 7 REF) |
| sched_sel_i | input | SW | Scheduler bank or select field |
| sched_addr_i | input | DW | Scheduler address |
| sched_ready_o | output | 1 | Scheduler command taken this cycle |
| odt_i | input | 1 | Termination control requested by scheduler |
| cke_i | input | 1 | Clock-enable requested by scheduler |
| cmd_o | output | 3 | Command to DRAM bus |
| sel_o | output | SW | Select field to DRAM bus |
| addr_o | output | DW | Address to DRAM bus |
| odt_o | output | 1 | Termination control to DRAM |
| cke_o | output | 1 | Clock-enable to DRAM |
| phase_o | output | 2 | Setting phase: 0 old, 1 updating, 2 new |
| applied_o | output | 1 | One-cycle pulse: new setting in effect |

## Verification
The bench withholds each idle condition in turn: one open bank, one bank still inside its precharge period, and a live burst. A guard that checked only one of these would acknowledge early.

It holds a read pending across the whole blackout. A design that drops stalled commands, or lets a command through one cycle early or late, shows a wrong `cmd_o` at T0+tMOD-1 or T0+tMOD. The same test keeps `cke_i` low with `odt_i` high, which catches a termination or clock-enable window that is off by one.

A back-to-back write request and a second reset with zero delays probe the re-acknowledge edge and the clamp to one cycle.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_DES = 3'd1, CMD_MRS = 3'd2, CMD_ACT = 3'd3,
    CMD_RD  = 3'd4, CMD_WR  = 3'd5, CMD_PRE = 3'd6, CMD_REF = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PH_OLD = 2'd0, PH_UPD = 2'd1, PH_NEW = 2'd2
  } phase_e;
endpackage

// File: rtl/mrs_idle_chk.sv
module mrs_idle_chk #(
  parameter int NB = 8
) (
  input  logic [NB-1:0] bank_pre_i,
  input  logic [NB-1:0] bank_trp_ok_i,
  input  logic          burst_busy_i,
  output logic          all_idle_o
);
  logic [NB-1:0] bank_ok;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_ok[b] = bank_pre_i[b] & bank_trp_ok_i[b];
  end

  assign all_idle_o = (&bank_ok) & ~burst_busy_i;
endmodule

// File: rtl/mrs_win_timer.sv
module mrs_win_timer #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,   // >= 1, window covers start cycle plus len-1
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mrs_guard.sv
module mrs_guard
  import mrs_guard_pkg::*;
#(
  parameter int NB = 8,
  parameter int CW = 6,
  parameter int SW = 3,
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cfg_tmod_i,
  input  logic [CW-1:0] cfg_tpd_i,
  input  logic          mrs_req_i,
  input  logic [SW-1:0] mrs_sel_i,
  input  logic [DW-1:0] mrs_data_i,
  output logic          mrs_ack_o,
  input  logic [NB-1:0] bank_pre_i,
  input  logic [NB-1:0] bank_trp_ok_i,
  input  logic          burst_busy_i,
  input  logic [2:0]    sched_cmd_i,
  input  logic [SW-1:0] sched_sel_i,
  input  logic [DW-1:0] sched_addr_i,
  output logic          sched_ready_o,
  input  logic          odt_i,
  input  logic          cke_i,
  output logic [2:0]    cmd_o,
  output logic [SW-1:0] sel_o,
  output logic [DW-1:0] addr_o,
  output logic          odt_o,
  output logic          cke_o,
  output logic [1:0]    phase_o,
  output logic          applied_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          cfg_loaded_q;
  logic [CW-1:0] tmod_q, tpd_q;
  logic          all_idle, mod_busy, pd_busy;
  logic          issue, upd, upd_q, new_q;

  // delays captured once; zero clamps to one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_loaded_q <= 1'b0;
      tmod_q       <= ONE;
      tpd_q        <= ONE;
    end else if (!cfg_loaded_q) begin
      cfg_loaded_q <= 1'b1;
      tmod_q       <= (cfg_tmod_i == '0) ? ONE : cfg_tmod_i;
      tpd_q        <= (cfg_tpd_i  == '0) ? ONE : cfg_tpd_i;
    end
  end

  mrs_idle_chk #(.NB(NB)) u_idle (
    .bank_pre_i    (bank_pre_i),
    .bank_trp_ok_i (bank_trp_ok_i),
    .burst_busy_i  (burst_busy_i),
    .all_idle_o    (all_idle)
  );

  mrs_win_timer #(.CW(CW)) u_mod_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue),
    .len_i   (tmod_q),
    .busy_o  (mod_busy)
  );

  mrs_win_timer #(.CW(CW)) u_pd_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue),
    .len_i   (tpd_q),
    .busy_o  (pd_busy)
  );

  assign issue         = mrs_req_i & all_idle & cfg_loaded_q & ~mod_busy;
  assign upd           = issue | mod_busy;
  assign mrs_ack_o     = issue;
  assign sched_ready_o = ~upd;

  always_comb begin
    if (issue) begin
      cmd_o  = CMD_MRS;
      sel_o  = mrs_sel_i;
      addr_o = mrs_data_i;
    end else if (mod_busy) begin
      cmd_o  = CMD_NOP;
      sel_o  = '0;
      addr_o = '0;
    end else begin
      cmd_o  = sched_cmd_i;
      sel_o  = sched_sel_i;
      addr_o = sched_addr_i;
    end
  end

  assign odt_o = odt_i & ~upd;
  assign cke_o = cke_i | issue | pd_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      new_q <= 1'b0;
    end else begin
      upd_q <= upd;
      if (issue) new_q <= 1'b1;
    end
  end

  // first cycle after the window, even if another write issues then
  assign applied_o = upd_q & ~mod_busy;
  assign phase_o   = upd ? PH_UPD : (new_q ? PH_NEW : PH_OLD);
endmodule

// File: rtl/mrs_guard_chk.sv
module mrs_guard_chk #(
  parameter int NB = 8,
  parameter int CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mrs_req_i,
  input logic          mrs_ack_o,
  input logic [NB-1:0] bank_pre_i,
  input logic [NB-1:0] bank_trp_ok_i,
  input logic          burst_busy_i,
  input logic [2:0]    sched_cmd_i,
  input logic          sched_ready_o,
  input logic [2:0]    cmd_o,
  input logic          odt_o,
  input logic          cke_o,
  input logic          applied_o,
  input logic [CW-1:0] tmod_q,
  input logic [CW-1:0] tpd_q
);
  logic [CW:0] age_q;
  logic        seen_q, is_mrs, in_win, in_pd;

  assign is_mrs = (cmd_o == 3'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q  <= '0;
      seen_q <= 1'b0;
    end else if (is_mrs) begin
      age_q  <= (CW+1)'(1);
      seen_q <= 1'b1;
    end else if (age_q != '1) begin
      age_q  <= age_q + (CW+1)'(1);
    end
  end

  assign in_win = seen_q && (age_q < {1'b0, tmod_q});
  assign in_pd  = seen_q && (age_q < {1'b0, tpd_q});

  // R2
  idle_before_mrs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> ((&bank_pre_i) && (&bank_trp_ok_i) && !burst_busy_i));
  // R3
  ack_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_ack_o |-> (mrs_req_i && is_mrs));
  // R4
  quiet_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |-> (cmd_o == 3'd0 || cmd_o == 3'd1));
  // R4
  stall_on_mrs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs || in_win) |-> !sched_ready_o);
  // R5
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sched_ready_o && sched_cmd_i != 3'd0) |-> (cmd_o == sched_cmd_i));
  // R6
  odt_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs || in_win) |-> !odt_o);
  // R7
  cke_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs || in_pd) |-> cke_o);
  // R9
  applied_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    applied_o |-> (seen_q && age_q == {1'b0, tmod_q}));
endmodule

bind mrs_guard mrs_guard_chk #(.NB(NB), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mrs_req_i     (mrs_req_i),
  .mrs_ack_o     (mrs_ack_o),
  .bank_pre_i    (bank_pre_i),
  .bank_trp_ok_i (bank_trp_ok_i),
  .burst_busy_i  (burst_busy_i),
  .sched_cmd_i   (sched_cmd_i),
  .sched_ready_o (sched_ready_o),
  .cmd_o         (cmd_o),
  .odt_o         (odt_o),
  .cke_o         (cke_o),
  .applied_o     (applied_o),
  .tmod_q        (tmod_q),
  .tpd_q         (tpd_q)
);

// File: tb/mrs_guard_bench.sv
`timescale 1ns/1ps
module mrs_guard_bench;
  localparam int NB = 8, CW = 6, SW = 3, DW = 14;
  localparam logic [2:0] C_NOP = 3'd0, C_MRS = 3'd2, C_RD = 3'd4, C_WR = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [CW-1:0] cfg_tmod, cfg_tpd;
  logic          mrs_req, mrs_ack;
  logic [SW-1:0] mrs_sel, sched_sel, sel_o;
  logic [DW-1:0] mrs_data, sched_addr, addr_o;
  logic [NB-1:0] bank_pre, bank_trp;
  logic          burst_busy, sched_ready, odt_i, cke_i, odt_o, cke_o, applied;
  logic [2:0]    sched_cmd, cmd_o;
  logic [1:0]    phase;

  int checks = 0, errors = 0;
  bit done = 0;

  mrs_guard #(.NB(NB), .CW(CW), .SW(SW), .DW(DW)) u_mrs_guard (
    .clk_i(clk), .rst_ni(rst_n), .cfg_tmod_i(cfg_tmod), .cfg_tpd_i(cfg_tpd),
    .mrs_req_i(mrs_req), .mrs_sel_i(mrs_sel), .mrs_data_i(mrs_data),
    .mrs_ack_o(mrs_ack), .bank_pre_i(bank_pre), .bank_trp_ok_i(bank_trp),
    .burst_busy_i(burst_busy), .sched_cmd_i(sched_cmd), .sched_sel_i(sched_sel),
    .sched_addr_i(sched_addr), .sched_ready_o(sched_ready), .odt_i(odt_i),
    .cke_i(cke_i), .cmd_o(cmd_o), .sel_o(sel_o), .addr_o(addr_o),
    .odt_o(odt_o), .cke_o(cke_o), .phase_o(phase), .applied_o(applied)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input int tmod, input int tpd);
    rst_n = 1'b0; cfg_tmod = CW'(tmod); cfg_tpd = CW'(tpd);
    mrs_req = 0; mrs_sel = '0; mrs_data = '0;
    bank_pre = '1; bank_trp = '1; burst_busy = 0;
    sched_cmd = C_NOP; sched_sel = '0; sched_addr = '0; odt_i = 0; cke_i = 1;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  // R1: no acknowledge before capture; reset outputs
  task automatic t_reset();
    do_reset(4, 6);
    mrs_req = 1; #1;
    chk("R1", "ack before capture", mrs_ack, 0);
    chk("R8", "phase after reset", phase, 0);
    chk("R9", "applied after reset", applied, 0);
    chk("R1", "cmd before capture", cmd_o, C_NOP);
    mrs_req = 0;
    tick();
  endtask

  // R2: each idle condition blocks the write
  task automatic t_not_idle();
    mrs_req = 1; mrs_sel = 3'd5; mrs_data = 14'h1a5;
    bank_pre = 8'hfb; #1;
    chk("R2", "ack with open bank", mrs_ack, 0);
    chk("R2", "cmd with open bank", cmd_o, C_NOP);
    tick(); bank_pre = '1; bank_trp = 8'h7f; #1;
    chk("R2", "ack in precharge period", mrs_ack, 0);
    tick(); bank_trp = '1; burst_busy = 1; #1;
    chk("R2", "ack during burst", mrs_ack, 0);
    chk("R8", "phase while waiting", phase, 0);
    tick(); burst_busy = 0;
  endtask

  // R3..R9: full window with a read stalled throughout
  task automatic t_window();
    sched_cmd = C_RD; sched_addr = 14'h0033; odt_i = 1; cke_i = 0; #1;
    chk("R3", "ack when idle", mrs_ack, 1);
    chk("R3", "cmd at T0", cmd_o, C_MRS);
    chk("R3", "sel at T0", sel_o, 5);
    chk("R3", "addr at T0", addr_o, 'h1a5);
    chk("R10", "ready at T0", sched_ready, 0);
    chk("R6", "odt at T0", odt_o, 0);
    chk("R7", "cke at T0", cke_o, 1);
    chk("R8", "phase at T0", phase, 1);
    for (int k = 1; k <= 7; k++) begin
      tick();
      if (k == 1) mrs_req = 0;
      #1;
      if (k < 4) begin
        chk("R4", "cmd in window", cmd_o, C_NOP);
        chk("R4", "ready in window", sched_ready, 0);
        chk("R6", "odt in window", odt_o, 0);
        chk("R8", "phase in window", phase, 1);
        chk("R9", "applied in window", applied, 0);
      end else begin
        chk("R5", "stalled read issued", cmd_o, C_RD);
        chk("R5", "stalled addr issued", addr_o, 'h33);
        chk("R5", "ready after window", sched_ready, 1);
        chk("R6", "odt after window", odt_o, 1);
        chk("R8", "phase after window", phase, 2);
        chk("R9", "applied pulse", applied, (k == 4) ? 1 : 0);
      end
      chk("R7", "cke hold", cke_o, (k < 6) ? 1 : 0);
    end
    sched_cmd = C_NOP; odt_i = 0; cke_i = 1;
    tick();
  endtask

  // R10: back-to-back requests, MRS wins over a write
  task automatic t_back_to_back();
    mrs_req = 1; sched_cmd = C_WR; #1;
    chk("R10", "first ack", mrs_ack, 1);
    for (int k = 1; k <= 4; k++) begin
      tick(); #1;
      if (k < 4) chk("R10", "second ack held", mrs_ack, 0);
      else begin
        chk("R10", "second ack at T0+tMOD", mrs_ack, 1);
        chk("R10", "mrs beats write", cmd_o, C_MRS);
        chk("R10", "write stalled", sched_ready, 0);
        chk("R9", "applied with reissue", applied, 1);
        chk("R8", "phase on reissue", phase, 1);
      end
    end
    tick(); mrs_req = 0;
    repeat (4) tick();
    #1;
    chk("R5", "write issued later", cmd_o, C_WR);
    sched_cmd = C_NOP;
    tick();
  endtask

  // R1: zero delays clamp to one cycle
  task automatic t_clamp();
    do_reset(0, 0);
    tick();
    mrs_req = 1; sched_cmd = C_RD; cke_i = 0; #1;
    chk("R1", "ack with clamp", mrs_ack, 1);
    chk("R7", "cke at T0 clamp", cke_o, 1);
    tick(); mrs_req = 0; #1;
    chk("R1", "read at T0+1", cmd_o, C_RD);
    chk("R9", "applied at T0+1", applied, 1);
    chk("R7", "cke released T0+1", cke_o, 0);
    chk("R8", "phase new T0+1", phase, 2);
    sched_cmd = C_NOP; cke_i = 1;
    tick();
  endtask

  initial begin
    t_reset();
    t_not_idle();
    t_window();
    t_back_to_back();
    t_clamp();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule